// File: doc/BRIEF.md
# Packed Carryless Multiply Lane

This block is one lane of a vector datapath. It takes a 64-bit slice of two vector source registers, splits each into packed elements of 8, 16, 32 or 64 bits chosen at run time, and multiplies matching elements without carries. For each element it returns either the lower or the upper half of the double-width polynomial product. The first operand can come from the first vector slice or from a scalar register. The scalar is zero-extended or truncated to the element width and the same value is used for every element.

The slice carries the absolute index of its element 0. Only elements whose absolute index lies in the window from the start index up to, but not including, the vector length are computed. All other elements return the old destination value supplied with the request. Two separate enable inputs select which element widths are legal. A request at a width that is not legal returns the old destination unchanged and raises an illegal flag.

Requests enter on a valid/ready handshake and results leave on another valid/ready handshake, one slice per transaction. A request is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the result is held unchanged and no new request is accepted. The result appears exactly one cycle after acceptance, whatever the operand values.

Top module: `cl_mul_lane`

## Requirements
- R1: With `hi_sel`=0, each active element of `out_data` equals the least significant SEW bits of the carryless product of its two operands.
- R2: With `hi_sel`=1, each active element of `out_data` equals the most significant SEW bits of the 2*SEW-bit carryless product.
- R3: With `scalar_mode`=1, the first operand of every element is `scalar` zero-extended or truncated to SEW bits. With `scalar_mode`=0, it is element i of `vs1`. The second operand is always element i of `vs2`.
- R4: `sew` is encoded 0=8, 1=16, 2=32 and 3=64 bits, giving 8, 4, 2 or 1 elements. Element 0 sits in the least significant bits, and element i of the result occupies the same bits as element i of the sources.
- R5: An element with local index i is active only when `vstart` <= `base_idx`+i < `vl`. An inactive element of `out_data` equals the matching bits of `old_vd`.
- R6: SEW=64 is legal only when `en_wide`=1, and SEW of 8, 16 or 32 is legal only when `en_narrow`=1. An illegal request yields `out_illegal`=1 and `out_data`=`old_vd`. A legal request yields `out_illegal`=0.
- R7: `out_valid` rises in the cycle right after an accepted request, regardless of operand values. It never rises without an accepted request.
- R8: While `out_valid`=1 and `out_ready`=0, `out_data` and `out_illegal` hold their values and `in_ready`=0. When `out_ready`=1, a new request may be accepted in the same cycle as the drain.
- R9: During and right after reset, `out_valid`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be accepted |
| sew | input | 2 | Element width code |
| hi_sel | input | 1 | 1 selects the upper product half |
| scalar_mode | input | 1 | 1 takes the first operand from `scalar` |
| en_wide | input | 1 | Enables the 64-bit width |
| en_narrow | input | 1 | Enables the 8, 16 and 32-bit widths |
| vs1 | input | DATA_W | First vector source slice |
| vs2 | input | DATA_W | Second vector source slice |
| scalar | input | SCALAR_W | Scalar operand |
| old_vd | input | DATA_W | Previous destination slice |
| base_idx | input | IDX_W | Absolute index of element 0 of the slice |
| vstart | input | IDX_W | First active element index |
| vl | input | IDX_W | Vector length (one past the last active index) |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | DATA_W | Result slice |
| out_illegal | output | 1 | Request width was not legal |

## Verification
The hardest case to reach from the ports is a drain and a new acceptance in the same edge, right after a stretch of back-pressure. The bench stalls `out_ready` while a second request is already waiting. It checks that the first result stays frozen and that the second request is refused. It then raises `out_ready` and checks that the second result follows in the very next cycle. Partially active slices are another corner: the bench combines nonzero `base_idx` values with start and length windows that cut through the middle of a slice, so that computed elements and preserved old elements sit side by side.

// File: rtl/clm_pkg.sv
package clm_pkg;
  typedef enum logic [1:0] {
    SEW_E8  = 2'd0,
    SEW_E16 = 2'd1,
    SEW_E32 = 2'd2,
    SEW_E64 = 2'd3
  } sew_e;

  localparam int NUM_SEW  = 4;
  localparam int MIN_EW   = 8;
endpackage

// File: rtl/clm_core.sv
// Full-width carryless product of two W-bit polynomials (fixed XOR tree).
module clm_core #(
  parameter int W = 8
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] prod_o
);
  logic [2*W-1:0] a_ext;
  assign a_ext = {{W{1'b0}}, a_i};

  always_comb begin
    prod_o = '0;
    for (int k = 0; k < W; k++) begin
      prod_o = prod_o ^ ({2*W{b_i[k]}} & (a_ext << k));
    end
  end
endmodule

// File: rtl/clm_active.sv
// Per-byte activity: a byte is active when its element's absolute index is in [vstart, vl).
module clm_active #(
  parameter int DATA_W = 64,
  parameter int IDX_W  = 16,
  localparam int NBYTE = DATA_W / 8
) (
  input  logic [1:0]       sew_i,
  input  logic [IDX_W-1:0] base_i,
  input  logic [IDX_W-1:0] vstart_i,
  input  logic [IDX_W-1:0] vl_i,
  output logic [NBYTE-1:0] byte_act_o
);
  logic [IDX_W:0] elem_idx;
  logic [IDX_W:0] abs_idx;

  always_comb begin
    elem_idx   = '0;
    abs_idx    = '0;
    byte_act_o = '0;
    for (int j = 0; j < NBYTE; j++) begin
      elem_idx      = (IDX_W+1)'(j >> sew_i);
      abs_idx       = {1'b0, base_i} + elem_idx;
      byte_act_o[j] = (abs_idx >= {1'b0, vstart_i}) && (abs_idx < {1'b0, vl_i});
    end
  end
endmodule

// File: rtl/clm_legal.sv
// Width legality against the two independently enabled variants.
module clm_legal (
  input  logic [1:0] sew_i,
  input  logic       en_wide_i,
  input  logic       en_narrow_i,
  output logic       legal_o
);
  import clm_pkg::*;
  sew_e sew_q;
  assign sew_q = sew_e'(sew_i);

  always_comb begin
    unique case (sew_q)
      SEW_E64: legal_o = en_wide_i;
      default: legal_o = en_narrow_i;
    endcase
  end
endmodule

// File: rtl/cl_mul_lane.sv
module cl_mul_lane #(
  parameter int DATA_W   = 64,
  parameter int SCALAR_W = 64,
  parameter int IDX_W    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [1:0]          sew,
  input  logic                hi_sel,
  input  logic                scalar_mode,
  input  logic                en_wide,
  input  logic                en_narrow,
  input  logic [DATA_W-1:0]   vs1,
  input  logic [DATA_W-1:0]   vs2,
  input  logic [SCALAR_W-1:0] scalar,
  input  logic [DATA_W-1:0]   old_vd,
  input  logic [IDX_W-1:0]    base_idx,
  input  logic [IDX_W-1:0]    vstart,
  input  logic [IDX_W-1:0]    vl,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [DATA_W-1:0]   out_data,
  output logic                out_illegal
);
  import clm_pkg::*;

  localparam int NBYTE = DATA_W / 8;

  logic [DATA_W-1:0] res_lo [NUM_SEW];
  logic [DATA_W-1:0] res_hi [NUM_SEW];
  logic [DATA_W-1:0] res_sel;
  logic [DATA_W-1:0] merged;
  logic [NBYTE-1:0]  byte_act;
  logic              legal;
  logic              accept;

  // One packed engine per element width; all run in parallel, sew picks one.
  for (genvar g = 0; g < NUM_SEW; g++) begin : g_w
    localparam int W = MIN_EW << g;
    localparam int N = DATA_W / W;
    logic [W-1:0]      sc_w;
    logic [DATA_W-1:0] a_sel;
    logic [DATA_W-1:0] lo_v;
    logic [DATA_W-1:0] hi_v;

    assign sc_w  = W'(scalar);
    assign a_sel = scalar_mode ? {N{sc_w}} : vs1;

    for (genvar e = 0; e < N; e++) begin : g_e
      logic [2*W-1:0] prod;
      clm_core #(.W(W)) u_core (
        .a_i   (a_sel[e*W +: W]),
        .b_i   (vs2[e*W +: W]),
        .prod_o(prod)
      );
      assign lo_v[e*W +: W] = prod[W-1:0];
      assign hi_v[e*W +: W] = prod[2*W-1:W];
    end

    assign res_lo[g] = lo_v;
    assign res_hi[g] = hi_v;
  end

  assign res_sel = hi_sel ? res_hi[sew] : res_lo[sew];

  clm_active #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_active (
    .sew_i     (sew),
    .base_i    (base_idx),
    .vstart_i  (vstart),
    .vl_i      (vl),
    .byte_act_o(byte_act)
  );

  clm_legal u_legal (
    .sew_i      (sew),
    .en_wide_i  (en_wide),
    .en_narrow_i(en_narrow),
    .legal_o    (legal)
  );

  always_comb begin
    for (int j = 0; j < NBYTE; j++) begin
      merged[j*8 +: 8] = byte_act[j] ? res_sel[j*8 +: 8] : old_vd[j*8 +: 8];
    end
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_illegal <= 1'b0;
    end else if (accept) begin
      out_valid   <= 1'b1;
      out_illegal <= !legal;
      out_data    <= legal ? merged : old_vd;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end
endmodule

// File: rtl/cl_mul_lane_chk.sv
module cl_mul_lane_chk #(
  parameter int DATA_W = 64,
  parameter int IDX_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [1:0]        sew,
  input logic              en_wide,
  input logic              en_narrow,
  input logic [DATA_W-1:0] old_vd,
  input logic [IDX_W-1:0]  vl,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_illegal
);
  a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_illegal)));

  a_r8_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r6_wide_off: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && sew == 2'd3 && !en_wide) |=> (out_illegal && out_data == $past(old_vd)));

  a_r6_narrow_off: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && sew != 2'd3 && !en_narrow) |=> (out_illegal && out_data == $past(old_vd)));

  a_r5_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && vl == '0) |=> (out_data == $past(old_vd)));
endmodule

bind cl_mul_lane cl_mul_lane_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .sew(sew), .en_wide(en_wide), .en_narrow(en_narrow), .old_vd(old_vd),
  .vl(vl), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_illegal(out_illegal)
);

// File: tb/cl_mul_lane_test.sv
module cl_mul_lane_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 64;
  localparam int IW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [1:0] sew = '0;
  logic hi_sel = 1'b0, scalar_mode = 1'b0, en_wide = 1'b1, en_narrow = 1'b1;
  logic [DW-1:0] vs1 = '0, vs2 = '0, old_vd = '0;
  logic [63:0] scalar = '0;
  logic [IW-1:0] base_idx = '0, vstart = '0, vl = 16'd8;
  logic out_valid, out_ready = 1'b1, out_illegal;
  logic [DW-1:0] out_data;

  int n_chk = 0;
  int n_fail = 0;
  logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

  always #(CLK_PERIOD/2) clk = ~clk;

  cl_mul_lane #(.DATA_W(DW), .SCALAR_W(64), .IDX_W(IW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .sew(sew), .hi_sel(hi_sel), .scalar_mode(scalar_mode),
    .en_wide(en_wide), .en_narrow(en_narrow), .vs1(vs1), .vs2(vs2),
    .scalar(scalar), .old_vd(old_vd), .base_idx(base_idx), .vstart(vstart),
    .vl(vl), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_illegal(out_illegal)
  );

  function automatic logic [63:0] next_rand();
    lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
    return lfsr ^ {lfsr[31:0], lfsr[63:32]};
  endfunction

  // Bit-serial shift-and-XOR reference built from the requirements.
  function automatic logic [64:0] model();
    int w = 8 << sew;
    int n = 64 / w;
    logic [63:0] mask = (w == 64) ? '1 : ((64'd1 << w) - 1);
    logic [63:0] res = old_vd;
    if ((sew == 2'd3) ? !en_wide : !en_narrow) return {1'b1, old_vd};
    for (int e = 0; e < n; e++) begin
      logic [63:0] a, b, val;
      logic [127:0] p;
      int abs_i = int'(base_idx) + e;
      a = (scalar_mode ? scalar : (vs1 >> (e*w))) & mask;
      b = (vs2 >> (e*w)) & mask;
      p = '0;
      for (int k = 0; k < w; k++) if (b[k]) p = p ^ ({64'd0, a} << k);
      val = hi_sel ? (64'(p >> w) & mask) : (p[63:0] & mask);
      if (abs_i >= int'(vstart) && abs_i < int'(vl))
        res = (res & ~(mask << (e*w))) | (val << (e*w));
    end
    return {1'b0, res};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Issue one request with out_ready high and check the result one cycle later.
  task automatic run_one(string req);
    logic [64:0] m;
    @(negedge clk);
    out_ready = 1'b1;
    in_valid  = 1'b1;
    m = model();
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " R7 valid"}, 64'(out_valid), 64'd1);
    chk({req, " data"}, out_data, m[63:0]);
    chk({req, " illegal"}, 64'(out_illegal), 64'(m[64]));
  endtask

  task automatic defaults();
    sew = 2'd0; hi_sel = 0; scalar_mode = 0; en_wide = 1; en_narrow = 1;
    base_idx = '0; vstart = '0; vl = 16'd8; old_vd = '0;
  endtask

  task automatic t_reset();
    chk("R9 valid in reset", 64'(out_valid), 64'd0);
    chk("R9 ready in reset", 64'(in_ready), 64'd1);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R9 valid after reset", 64'(out_valid), 64'd0);
  endtask

  task automatic t_layout();
    defaults();
    vs1 = 64'h3; vs2 = 64'h3;
    run_one("R4 byte0");
    chk("R4 byte0 explicit", out_data, 64'h5);
  endtask

  task automatic t_sweep();
    logic [63:0] pats [4] = '{64'hFFFF_FFFF_FFFF_FFFF, 64'hAAAA_5555_F0F0_0F0F,
                               64'h8000_0000_0000_0001, 64'h0123_4567_89AB_CDEF};
    for (int s = 0; s < 4; s++) begin
      for (int h = 0; h < 2; h++) begin
        for (int p = 0; p < 4; p++) begin
          defaults();
          sew = 2'(s); hi_sel = h[0];
          vs1 = pats[p]; vs2 = pats[3-p];
          run_one(h ? "R2 hi" : "R1 lo");
          vs1 = next_rand(); vs2 = next_rand();
          run_one(h ? "R2 hi rnd" : "R1 lo rnd");
        end
      end
    end
  endtask

  task automatic t_scalar();
    defaults();
    scalar_mode = 1; scalar = 64'h102; vs2 = 64'h0102_0304_0506_0708;
    run_one("R3 trunc");
    chk("R3 trunc explicit", out_data, 64'h0204_0608_0A0C_0E10);
    for (int s = 0; s < 4; s++) begin
      for (int h = 0; h < 2; h++) begin
        defaults();
        scalar_mode = 1; sew = 2'(s); hi_sel = h[0];
        scalar = next_rand(); vs1 = next_rand(); vs2 = next_rand();
        run_one("R3 bcast");
      end
    end
  endtask

  task automatic t_window();
    defaults();
    old_vd = 64'hAAAA_AAAA_AAAA_AAAA; vs1 = '0; vs2 = '0;
    vstart = 16'd2; vl = 16'd5;
    run_one("R5 mid");
    chk("R5 mid explicit", out_data, 64'hAAAA_AA00_0000_AAAA);
    defaults();
    sew = 2'd1; base_idx = 16'd6; vstart = '0; vl = 16'd7;
    old_vd = next_rand(); vs1 = next_rand(); vs2 = next_rand();
    run_one("R5 base");
    defaults();
    sew = 2'd2; vl = '0; old_vd = next_rand(); vs1 = next_rand(); vs2 = next_rand();
    run_one("R5 vl0");
    chk("R5 vl0 explicit", out_data, old_vd);
    defaults();
    sew = 2'd0; base_idx = 16'd100; vstart = 16'd103; vl = 16'd200;
    old_vd = next_rand(); vs1 = next_rand(); vs2 = next_rand();
    run_one("R5 vstart");
  endtask

  task automatic t_legal();
    defaults();
    sew = 2'd3; en_wide = 0; old_vd = 64'h1234_5678_9ABC_DEF0;
    vs1 = next_rand(); vs2 = next_rand();
    run_one("R6 wide off");
    chk("R6 wide off flag", 64'(out_illegal), 64'd1);
    for (int s = 0; s < 3; s++) begin
      defaults();
      sew = 2'(s); en_narrow = 0; en_wide = 1;
      old_vd = next_rand(); vs1 = next_rand(); vs2 = next_rand();
      run_one("R6 narrow off");
    end
    defaults();
    sew = 2'd3; en_narrow = 0; vs1 = next_rand(); vs2 = next_rand();
    run_one("R6 wide only");
    chk("R6 wide only flag", 64'(out_illegal), 64'd0);
  endtask

  task automatic t_backpressure();
    logic [64:0] ma, mb;
    logic [63:0] held;
    defaults();
    @(negedge clk);
    out_ready = 1'b0;
    vs1 = next_rand(); vs2 = next_rand(); ma = model();
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R8 first result", out_data, ma[63:0]);
    held = out_data;
    sew = 2'd1; hi_sel = 1; vs1 = next_rand(); vs2 = next_rand(); mb = model();
    for (int c = 0; c < 3; c++) begin
      chk("R8 stall ready", 64'(in_ready), 64'd0);
      @(posedge clk);
      @(negedge clk);
      chk("R8 hold", out_data, held);
      chk("R8 hold valid", 64'(out_valid), 64'd1);
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 second valid", 64'(out_valid), 64'd1);
    chk("R8 second data", out_data, mb[63:0]);
    @(posedge clk);
    @(negedge clk);
    chk("R7 drains", 64'(out_valid), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2);
    t_reset();
    t_layout();
    t_sweep();
    t_scalar();
    t_window();
    t_legal();
    t_backpressure();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule